// File: doc/BRIEF.md
# Sector Write-Protect Qualifier

This block decides, for each program or erase request, whether the addressed sector may be written. It merges two active-low hardware protect pins with a bank of per-block software lock bits. The top-boot pin guards the top boot region, which is the highest sixteen sectors (64 KByte) of the array. The general pin guards every other sector. Each pin is combined only with the lock bit of its own group.

A request is judged once, on the cycle it is accepted. The verdict appears one cycle later as a single-cycle grant or deny pulse. A granted operation keeps the block busy until the array signals completion. While busy, the block holds the target block index, ignores new requests and ignores movement on the protect pins.

A readback port returns the raw lock bit of any block. The value it returns comes from the lock register alone, so it can read "unlocked" while a pin still protects that block.

Top module: `wp_qualifier`

## Requirements
- R1: After synchronous reset, grant, deny and busy are all low.
- R2: A request to a top boot sector (sector index 240 to 255 with default parameters) while top_prot_n is low is denied, whatever the lock bit of block 15 holds.
- R3: A request to any sector below the top boot region while gen_prot_n is low is denied, whatever that sector's block lock bit holds.
- R4: The pins act independently. top_prot_n low has no effect on sectors outside the top boot region, and gen_prot_n low has no effect on top boot sectors.
- R5: When the pin for a sector's group is high, the request is denied if the lock bit of block `req_sector >> 4` is 1 and granted if it is 0.
- R6: rd_lock equals lock_bits[rd_block] at all times, independent of the protect pins.
- R7: A denied request yields deny high for exactly the one cycle after acceptance, with grant low and busy remaining low.
- R8: A granted request yields grant high for the one cycle after acceptance. busy rises with it and stays high until the cycle after op_done is sampled high.
- R9: While busy, req_valid is ignored: neither grant nor deny is raised.
- R10: While busy, changes on top_prot_n, gen_prot_n or lock_bits neither end the operation nor change active_block.
- R11: The boundary between groups is exact. Sector 239 belongs to the general group and sector 240 to the top boot group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Program/erase request strobe |
| req_sector | input | 8 | Target sector index |
| lock_bits | input | 16 | Write-lock bit per 64 KByte block |
| top_prot_n | input | 1 | Top-boot protect pin, active low |
| gen_prot_n | input | 1 | General protect pin, active low |
| op_done | input | 1 | Operation complete from the array |
| rd_block | input | 4 | Block selected for lock readback |
| rd_lock | output | 1 | Lock register bit of rd_block |
| grant | output | 1 | One-cycle grant pulse |
| deny | output | 1 | One-cycle deny pulse |
| busy | output | 1 | Granted operation in progress |
| active_block | output | 4 | Block of the operation in progress |

## Verification
The hardest situation to reach is a protect pin, or a lock bit, changing in the middle of a granted operation, together with a fresh request arriving during that operation. The bench gets there in one sequence. It opens an operation on an unlocked sector and holds op_done low. It then drops both pins, sets every lock bit and fires a request at a locked sector. Throughout, it confirms that no pulse appears, that busy stays high and that active_block does not move. Only after all of that does it release op_done.

// File: rtl/wpq_pkg.sv
package wpq_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } wpq_state_e;

    // Verdict inputs for one request
    typedef struct packed {
        logic in_top;    // sector lies in the top boot group
        logic soft_lock; // lock bit of the sector's block
        logic pin_low;   // the group's hardware pin is asserted
    } prot_info_t;

    function automatic logic is_blocked(input prot_info_t p);
        return p.soft_lock | p.pin_low;
    endfunction

endpackage

// File: rtl/wpq_decode.sv
module wpq_decode #(
    parameter int SECTOR_W    = 8,
    parameter int BLK_SHIFT   = 4,
    parameter int TOP_SECTORS = 16,
    localparam int BLK_W       = SECTOR_W - BLK_SHIFT,
    localparam int NUM_SECTORS = 1 << SECTOR_W
) (
    input  logic [SECTOR_W-1:0] sector,
    output logic [BLK_W-1:0]    blk,
    output logic                in_top
);
    localparam int TOP_BASE = NUM_SECTORS - TOP_SECTORS;

    always_comb begin
        blk    = sector[SECTOR_W-1:BLK_SHIFT];
        in_top = (int'(sector) >= TOP_BASE);
    end
endmodule

// File: rtl/wpq_eval.sv
module wpq_eval
    import wpq_pkg::*;
#(
    parameter int BLK_W = 4,
    localparam int NUM_BLOCKS = 1 << BLK_W
) (
    input  logic [BLK_W-1:0]      blk,
    input  logic                  in_top,
    input  logic [NUM_BLOCKS-1:0] lock_bits,
    input  logic                  top_prot_n,
    input  logic                  gen_prot_n,
    output logic                  blocked
);
    prot_info_t info;

    always_comb begin
        info.in_top    = in_top;
        info.soft_lock = lock_bits[blk];
        info.pin_low   = in_top ? ~top_prot_n : ~gen_prot_n;
        blocked        = is_blocked(info);
    end
endmodule

// File: rtl/wpq_ctrl.sv
module wpq_ctrl
    import wpq_pkg::*;
#(
    parameter int BLK_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             blocked,
    input  logic [BLK_W-1:0] blk,
    input  logic             op_done,
    output logic             grant,
    output logic             deny,
    output logic             busy,
    output logic [BLK_W-1:0] active_block
);
    wpq_state_e       state_q;
    logic             grant_q, deny_q;
    logic [BLK_W-1:0] blk_q;
    logic             accept;

    assign accept = req_valid && (state_q == ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            grant_q <= 1'b0;
            deny_q  <= 1'b0;
            blk_q   <= '0;
        end else begin
            grant_q <= accept && !blocked;
            deny_q  <= accept && blocked;
            case (state_q)
                ST_IDLE: if (accept && !blocked) begin
                    state_q <= ST_BUSY;
                    blk_q   <= blk;
                end
                ST_BUSY: if (op_done) state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign grant        = grant_q;
    assign deny         = deny_q;
    assign busy         = (state_q == ST_BUSY);
    assign active_block = blk_q;

    // R7: a deny never opens an operation
    a_r7_deny_idle: assert property (@(posedge clk) disable iff (rst)
        deny |-> !busy && !grant);
    // R8: grant only on the first busy cycle
    a_r8_grant_starts_op: assert property (@(posedge clk) disable iff (rst)
        grant |-> $rose(busy));
    // R9: no verdict while an operation is already running
    a_r9_quiet_when_busy: assert property (@(posedge clk) disable iff (rst)
        busy && !op_done |=> !deny && !grant);
    // R10: target held for the whole operation
    a_r10_block_held: assert property (@(posedge clk) disable iff (rst)
        busy && !op_done |=> $stable(active_block));
endmodule

// File: rtl/wp_qualifier.sv
module wp_qualifier #(
    parameter int SECTOR_W    = 8,
    parameter int BLK_SHIFT   = 4,
    parameter int TOP_SECTORS = 16,
    localparam int BLK_W      = SECTOR_W - BLK_SHIFT,
    localparam int NUM_BLOCKS = 1 << BLK_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    input  logic [SECTOR_W-1:0]   req_sector,
    input  logic [NUM_BLOCKS-1:0] lock_bits,
    input  logic                  top_prot_n,
    input  logic                  gen_prot_n,
    input  logic                  op_done,
    input  logic [BLK_W-1:0]      rd_block,
    output logic                  rd_lock,
    output logic                  grant,
    output logic                  deny,
    output logic                  busy,
    output logic [BLK_W-1:0]      active_block
);
    logic [BLK_W-1:0] dec_blk;
    logic             dec_top;
    logic             blocked;

    wpq_decode #(.SECTOR_W(SECTOR_W), .BLK_SHIFT(BLK_SHIFT), .TOP_SECTORS(TOP_SECTORS)) u_dec (
        .sector (req_sector),
        .blk    (dec_blk),
        .in_top (dec_top)
    );

    wpq_eval #(.BLK_W(BLK_W)) u_eval (
        .blk        (dec_blk),
        .in_top     (dec_top),
        .lock_bits  (lock_bits),
        .top_prot_n (top_prot_n),
        .gen_prot_n (gen_prot_n),
        .blocked    (blocked)
    );

    wpq_ctrl #(.BLK_W(BLK_W)) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .blocked      (blocked),
        .blk          (dec_blk),
        .op_done      (op_done),
        .grant        (grant),
        .deny         (deny),
        .busy         (busy),
        .active_block (active_block)
    );

    // R6: readback is the register value, untouched by the pins
    assign rd_lock = lock_bits[rd_block];

    // R2: top pin low denies top boot sectors
    a_r2_top_pin: assert property (@(posedge clk) disable iff (rst)
        req_valid && !busy && dec_top && !top_prot_n |=> deny && !grant);
    // R3: general pin low denies the rest
    a_r3_gen_pin: assert property (@(posedge clk) disable iff (rst)
        req_valid && !busy && !dec_top && !gen_prot_n |=> deny && !grant);
    // R1: nothing active right after reset
    a_r1_reset_clear: assert property (@(posedge clk)
        $past(rst) |-> !grant && !deny && !busy);
endmodule

// File: tb/wp_qualifier_tb.sv
module wp_qualifier_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [7:0]  req_sector = '0;
    logic [15:0] lock_bits = '0;
    logic        top_prot_n = 1'b1;
    logic        gen_prot_n = 1'b1;
    logic        op_done = 1'b0;
    logic [3:0]  rd_block = '0;
    logic        rd_lock, grant, deny, busy;
    logic [3:0]  active_block;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    wp_qualifier u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_sector(req_sector),
        .lock_bits(lock_bits), .top_prot_n(top_prot_n), .gen_prot_n(gen_prot_n),
        .op_done(op_done), .rd_block(rd_block), .rd_lock(rd_lock),
        .grant(grant), .deny(deny), .busy(busy), .active_block(active_block)
    );

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic model_deny(input logic [7:0] s);
        if (s >= 8'd240) return !top_prot_n || lock_bits[15];
        return !gen_prot_n || lock_bits[s[7:4]];
    endfunction

    // One request; checks the verdict pulse; closes a granted op
    task automatic request(input logic [7:0] s, input string req);
        logic exp_deny;
        exp_deny = model_deny(s);
        @(negedge clk);
        req_sector = s; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(deny == exp_deny, req, deny, exp_deny);
        check(grant == !exp_deny, req, grant, !exp_deny);
        if (!exp_deny) begin
            op_done = 1'b1;
            @(negedge clk);
            op_done = 1'b0;
            check(!busy, {req, " busy clear"}, busy, 0);
        end
    endtask

    task automatic t_reset();
        check(!grant && !deny && !busy, "R1", {grant, deny, busy}, 0);
    endtask

    task automatic t_lock_only();
        top_prot_n = 1; gen_prot_n = 1; lock_bits = '0;
        request(8'd5, "R5 unlocked low");
        request(8'd250, "R5 unlocked top");
        lock_bits = 16'h0001;
        request(8'd5, "R5 locked blk0");
        request(8'd20, "R5 blk1 free");
        lock_bits = 16'h8000;
        request(8'd255, "R5 locked top");
        lock_bits = '0;
    endtask

    task automatic t_top_pin();
        top_prot_n = 0; gen_prot_n = 1; lock_bits = '0;
        request(8'd250, "R2 top pin");
        request(8'd100, "R4 top pin no effect");
        top_prot_n = 1;
    endtask

    task automatic t_gen_pin();
        gen_prot_n = 0; top_prot_n = 1; lock_bits = '0;
        request(8'd100, "R3 gen pin");
        request(8'd241, "R4 gen pin no effect");
        gen_prot_n = 1;
    endtask

    task automatic t_boundary();
        gen_prot_n = 0;
        request(8'd239, "R11 239 general");
        request(8'd240, "R11 240 top");
        gen_prot_n = 1; top_prot_n = 0;
        request(8'd239, "R11 239 free");
        request(8'd240, "R11 240 denied");
        top_prot_n = 1;
    endtask

    task automatic t_readback();
        top_prot_n = 0; lock_bits = '0; rd_block = 4'd15;
        @(negedge clk);
        check(rd_lock == 1'b0, "R6 cleared bit reads 0", rd_lock, 0);
        request(8'd250, "R6 still protected");
        lock_bits = 16'h8000;
        @(negedge clk);
        check(rd_lock == 1'b1, "R6 set bit reads 1", rd_lock, 1);
        top_prot_n = 1; lock_bits = '0;
    endtask

    task automatic t_deny_pulse();
        lock_bits = 16'h0004;
        request(8'd33, "R7 deny");
        check(!busy, "R7 busy low", busy, 0);
        @(negedge clk);
        check(!deny, "R7 one cycle", deny, 0);
        lock_bits = '0;
    endtask

    task automatic t_busy();
        lock_bits = '0;
        @(negedge clk);
        req_sector = 8'd50; req_valid = 1;
        @(negedge clk);
        req_valid = 0;
        check(grant && busy, "R8 grant", {grant, busy}, 3);
        check(active_block == 4'd3, "R10 block", active_block, 3);
        @(negedge clk);
        check(!grant, "R8 grant one cycle", grant, 0);
        gen_prot_n = 0; top_prot_n = 0; lock_bits = '1;
        req_sector = 8'd7; req_valid = 1;
        @(negedge clk);
        req_valid = 0;
        @(negedge clk);
        check(!deny && !grant, "R9 ignored", {grant, deny}, 0);
        check(busy, "R10 busy held", busy, 1);
        check(active_block == 4'd3, "R10 block held", active_block, 3);
        repeat (4) @(negedge clk);
        check(busy, "R8 busy until done", busy, 1);
        op_done = 1;
        @(negedge clk);
        op_done = 0;
        check(!busy, "R8 done", busy, 0);
        gen_prot_n = 1; top_prot_n = 1; lock_bits = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_lock_only();
        t_top_pin();
        t_gen_pin();
        t_boundary();
        t_readback();
        t_deny_pulse();
        t_busy();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #40000;
        errors++; checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule